// File: doc/BRIEF.md
# Banked Serial EEPROM Target with Reversible Block Write Protection

This block is the digital core of a two-wire-bus memory target. It fronts a 512-byte array held as two 256-byte banks and sees the bus as already-decoded events: start (also used for a repeated start), stop, one received byte at a time, and a request for one byte to transmit. It answers every received byte with an acknowledge or a refusal one cycle later, and it returns a read byte one cycle after each transmit request.

The one-byte word address chosen on the bus selects a byte inside the active bank. Two special control codes choose the active bank, and any target on the bus answers them whatever its strap inputs. Two more codes set protection on one of four 128-byte blocks or clear all protection. Those two codes work only while the high-voltage qualifier input is high. Data bytes are gathered in a page buffer and committed after the stop in a self-timed write cycle. While that cycle runs, every control byte is refused, so a master polls until it is acknowledged again.

Top module: `i2c_banked_eeprom`

## Requirements
- R1: After reset, bank 0 is active, no block is protected, `ack_valid_o` and `rd_valid_o` are low, and at most one of them is high in any cycle.
- R2: A control byte with bits [7:4]=1010 and bits [3:1] equal to `strap_i` (strap_i[2] on bit 3) is acknowledged when no write cycle runs. Bit 0 = 1 selects a read and 0 selects a write. If bits [3:1] differ from the straps, the byte is refused.
- R3: Each transmit request in a read returns the byte at the address pointer and then adds one to the pointer. Byte 0xFF of the active bank is followed by byte 0x00 of the same bank.
- R4: In a write, the byte after the control byte loads the 8-bit pointer. Each accepted data byte is placed at the pointer, and the pointer's low 4 bits then step with wrap, so more than 16 bytes overwrite earlier ones in the same 16-byte page.
- R5: A stop that closes a write holding at least one accepted data byte commits those bytes and starts a write cycle of WC_CYCLES clocks. All control bytes are refused from the cycle after the stop until the write cycle ends.
- R6: A data byte aimed at a protected block is refused, leaves the array and the pointer unchanged, and does not start a write cycle. Block index = {bank, pointer bit 7}.
- R7: Control byte 0110_0bb0 protects block bb, and 0110_1000 clears all protection. Each is acknowledged and acts only when `hv_i` is high. Otherwise it is refused and protection is unchanged.
- R8: Control bytes 0110_1100 and 0110_1110 select bank 0 and bank 1 and are acknowledged regardless of `strap_i`. Control byte 0110_11x1 is acknowledged when bank 0 is active and refused when bank 1 is active.
- R9: A repeated start during a write discards the buffered data bytes. Nothing is committed and no write cycle starts.
- R10: Data written in one bank reads back at the same address in that bank only. The other bank's byte at that address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Board strap inputs matched against control byte bits [3:1] |
| hv_i | input | 1 | High-voltage qualifier for protection commands |
| start_i | input | 1 | One-cycle start or repeated-start event |
| stop_i | input | 1 | One-cycle stop event |
| rx_valid_i | input | 1 | One-cycle strobe: a byte was received from the master |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | One-cycle request for the next byte to send |
| ack_valid_o | output | 1 | Response to the received byte is valid (one cycle after rx_valid_i) |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_valid_o | output | 1 | Read byte is valid (one cycle after tx_req_i) |
| rd_data_o | output | 8 | Byte sent to the master (0xFF outside a read) |

## Verification
A bank or protection flag that holds the wrong value shows up at the very next control byte or data byte as a wrong acknowledge. It can also surface as a read that returns the other bank's content. A pointer that steps wrongly gives a wrong byte on the next transmit request, and a page pointer that leaves its page is seen only when that page is read back after the write cycle. A write timer that is too short or too long shows as a poll acknowledged earlier or later than WC_CYCLES clocks after the stop.

// File: rtl/beep_pkg.sv
package beep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CTRL   = 3'd1,
        ST_WADDR  = 3'd2,
        ST_WDATA  = 3'd3,
        ST_RDATA  = 3'd4,
        ST_DUMMY  = 3'd5,
        ST_IGNORE = 3'd6
    } bus_st_e;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_MEM_WR   = 3'd1,
        CMD_MEM_RD   = 3'd2,
        CMD_PROT_SET = 3'd3,
        CMD_PROT_CLR = 3'd4,
        CMD_BANK_SEL = 3'd5,
        CMD_BANK_RD  = 3'd6
    } ctl_cmd_e;

endpackage

// File: rtl/beep_cmd_decode.sv
module beep_cmd_decode
    import beep_pkg::*;
(
    input  logic [7:0] ctl_i,
    input  logic [2:0] strap_i,
    output ctl_cmd_e   cmd_o,
    output logic [1:0] blk_o,
    output logic       bank_o
);
    always_comb begin
        cmd_o  = CMD_NONE;
        blk_o  = ctl_i[2:1];
        bank_o = ctl_i[1];
        if (ctl_i[7:4] == 4'b1010) begin
            if (ctl_i[3:1] == strap_i)
                cmd_o = ctl_i[0] ? CMD_MEM_RD : CMD_MEM_WR;
        end else if (ctl_i[7:4] == 4'b0110) begin
            casez (ctl_i[3:1])
                3'b0??:  cmd_o = ctl_i[0] ? CMD_NONE : CMD_PROT_SET;
                3'b100:  cmd_o = ctl_i[0] ? CMD_NONE : CMD_PROT_CLR;
                3'b11?:  cmd_o = ctl_i[0] ? CMD_BANK_RD : CMD_BANK_SEL;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/beep_prot_bank.sv
module beep_prot_bank #(
    parameter  int BLOCKS = 4,
    localparam int BW     = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_i,
    input  logic              set_en_i,
    input  logic [BW-1:0]     set_blk_i,
    input  logic              clr_en_i,
    input  logic              bank_we_i,
    input  logic              bank_val_i,
    output logic [BLOCKS-1:0] prot_o,
    output logic              bank_o
);
    typedef struct packed {
        logic [BLOCKS-1:0] prot;
        logic              bank;
    } pb_t;

    pb_t q, d;

    always_comb begin
        d = q;
        if (clr_en_i)
            d.prot = '0;
        else if (set_en_i)
            d.prot[set_blk_i] = 1'b1;
        if (bank_we_i)
            d.bank = bank_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prot_o = q.prot;
    assign bank_o = q.bank;

    // R7: protection changes only in a cycle qualified by the high-voltage input
    a_r7_prot_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (q.prot != $past(q.prot)) |-> $past(hv_i));
endmodule

// File: rtl/beep_wr_timer.sv
module beep_wr_timer #(
    parameter  int WC_CYCLES  = 64,
    parameter  int PAGE_BYTES = 16,
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          commit_o,
    output logic [PW-1:0] idx_o
);
    localparam int CW = $clog2(WC_CYCLES + 1);
    localparam int IW = PW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } tm_t;

    tm_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.cnt = CW'(WC_CYCLES);
            d.idx = '0;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.idx < IW'(PAGE_BYTES))
                d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = (q.cnt != '0);
    assign commit_o = busy_o && (q.idx < IW'(PAGE_BYTES));
    assign idx_o    = q.idx[PW-1:0];

    // R5: a new write cycle is never requested while one runs
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R5: the commit sweep begins at the first page slot
    a_r5_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (idx_o == '0));
endmodule

// File: rtl/beep_array.sv
module beep_array #(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/i2c_banked_eeprom.sv
module i2c_banked_eeprom
    import beep_pkg::*;
#(
    parameter int WC_CYCLES  = 64,
    parameter int PAGE_BYTES = 16,
    parameter int BANK_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    input  logic       hv_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       tx_req_i,
    output logic       ack_valid_o,
    output logic       ack_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o
);
    localparam int AB     = $clog2(BANK_BYTES);
    localparam int DEPTH  = 2 * BANK_BYTES;
    localparam int AW     = AB + 1;
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int BLOCKS = 4;
    localparam int BW     = $clog2(BLOCKS);

    typedef struct packed {
        bus_st_e                     st;
        logic [AB-1:0]               addr;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pvld;
        logic [AW-PW-1:0]            pbase;
        logic                        ack_v;
        logic                        ack;
        logic                        rd_v;
        logic [7:0]                  rd_data;
        logic                        commit_req;
    } regs_t;

    regs_t q, d;

    ctl_cmd_e          cmd;
    logic [1:0]        cmd_blk;
    logic              cmd_bank;
    logic [BLOCKS-1:0] prot;
    logic              bank;
    logic              set_en, clr_en, bank_we;
    logic              busy, commit;
    logic [PW-1:0]     cidx;
    logic [7:0]        mem_rdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [AW-1:0]     cur_full;
    logic [BW-1:0]     cur_blk;
    logic [BW-1:0]     wr_blk;
    logic              busy_any;

    beep_cmd_decode u_dec (
        .ctl_i   (rx_byte_i),
        .strap_i (strap_i),
        .cmd_o   (cmd),
        .blk_o   (cmd_blk),
        .bank_o  (cmd_bank)
    );

    beep_prot_bank #(.BLOCKS(BLOCKS)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_i       (hv_i),
        .set_en_i   (set_en),
        .set_blk_i  (cmd_blk),
        .clr_en_i   (clr_en),
        .bank_we_i  (bank_we),
        .bank_val_i (cmd_bank),
        .prot_o     (prot),
        .bank_o     (bank)
    );

    beep_wr_timer #(.WC_CYCLES(WC_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (q.commit_req),
        .busy_o   (busy),
        .commit_o (commit),
        .idx_o    (cidx)
    );

    assign mem_we    = commit && q.pvld[cidx];
    assign mem_waddr = {q.pbase, cidx};

    beep_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (q.pbuf[cidx]),
        .raddr_i ({bank, q.addr}),
        .rdata_o (mem_rdata)
    );

    assign busy_any = busy || q.commit_req;
    assign cur_full = {bank, q.addr};
    assign cur_blk  = cur_full[AW-1 -: BW];
    assign wr_blk   = mem_waddr[AW-1 -: BW];

    always_comb begin
        d            = q;
        d.ack_v      = 1'b0;
        d.ack        = 1'b0;
        d.rd_v       = 1'b0;
        d.commit_req = 1'b0;
        set_en       = 1'b0;
        clr_en       = 1'b0;
        bank_we      = 1'b0;

        if (start_i) begin
            if (q.st == ST_WDATA) d.pvld = '0;
            d.st = ST_CTRL;
        end else if (stop_i) begin
            if (q.st == ST_WDATA && (|q.pvld)) d.commit_req = 1'b1;
            d.st = ST_IDLE;
        end else if (rx_valid_i) begin
            d.ack_v = 1'b1;
            unique case (q.st)
                ST_CTRL: begin
                    d.st = ST_IGNORE;
                    unique case (cmd)
                        CMD_MEM_WR: if (!busy_any) begin
                            d.ack  = 1'b1;
                            d.st   = ST_WADDR;
                            d.pvld = '0;
                        end
                        CMD_MEM_RD: if (!busy_any) begin
                            d.ack = 1'b1;
                            d.st  = ST_RDATA;
                        end
                        CMD_PROT_SET: if (!busy_any && hv_i) begin
                            d.ack  = 1'b1;
                            set_en = 1'b1;
                            d.st   = ST_DUMMY;
                        end
                        CMD_PROT_CLR: if (!busy_any && hv_i) begin
                            d.ack  = 1'b1;
                            clr_en = 1'b1;
                            d.st   = ST_DUMMY;
                        end
                        CMD_BANK_SEL: if (!busy_any) begin
                            d.ack   = 1'b1;
                            bank_we = 1'b1;
                            d.st    = ST_DUMMY;
                        end
                        CMD_BANK_RD: if (!busy_any && !bank) begin
                            d.ack = 1'b1;
                            d.st  = ST_DUMMY;
                        end
                        default: d.ack = 1'b0;
                    endcase
                end
                ST_WADDR: begin
                    d.ack   = 1'b1;
                    d.addr  = rx_byte_i[AB-1:0];
                    d.pbase = {bank, rx_byte_i[AB-1:PW]};
                    d.st    = ST_WDATA;
                end
                ST_WDATA: begin
                    if (!prot[cur_blk]) begin
                        d.ack                     = 1'b1;
                        d.pbuf[q.addr[PW-1:0]]    = rx_byte_i;
                        d.pvld[q.addr[PW-1:0]]    = 1'b1;
                        d.addr = {q.addr[AB-1:PW], PW'(q.addr[PW-1:0] + 1'b1)};
                    end
                end
                ST_DUMMY: d.ack = 1'b1;
                default:  d.ack = 1'b0;
            endcase
        end else if (tx_req_i) begin
            d.rd_v = 1'b1;
            if (q.st == ST_RDATA) begin
                d.rd_data = mem_rdata;
                d.addr    = q.addr + 1'b1;
            end else begin
                d.rd_data = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_valid_o = q.ack_v;
    assign ack_o       = q.ack;
    assign rd_valid_o  = q.rd_v;
    assign rd_data_o   = q.rd_data;

    // R1: byte response and read data never appear together
    a_r1_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_valid_o, rd_valid_o}));
    // R5: control bytes are refused while a write cycle is pending or running
    a_r5_nack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !start_i && !stop_i && q.st == ST_CTRL && busy_any)
        |=> (ack_valid_o && !ack_o));
    // R6: the array is never written inside a protected block
    a_r6_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !prot[wr_blk]);
    // R6: a data byte into a protected block is refused and the pointer holds
    a_r6_prot_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !start_i && !stop_i && q.st == ST_WDATA && prot[cur_blk])
        |=> (!ack_o && q.addr == $past(q.addr)));
    // R4: data bytes keep the pointer inside its page
    a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !start_i && !stop_i && q.st == ST_WDATA)
        |=> (q.addr[AB-1:PW] == $past(q.addr[AB-1:PW])));
    // R3: each byte sent in a read steps the pointer by one within the bank
    a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !rx_valid_i && !start_i && !stop_i && q.st == ST_RDATA)
        |=> (q.addr == AB'($past(q.addr) + 1'b1)));
endmodule

// File: tb/i2c_banked_eeprom_tb.sv
module i2c_banked_eeprom_tb;
    localparam int WC = 64;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CTL_W   = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CTL_R   = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] PCLR    = 8'b0110_1000;
    localparam logic [7:0] BSEL0   = 8'b0110_1100;
    localparam logic [7:0] BSEL1   = 8'b0110_1110;
    localparam logic [7:0] BREAD   = 8'b0110_1101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0, tx_req_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic ack_valid_o, ack_o, rd_valid_o;
    logic [7:0] rd_data_o;

    int checks = 0;
    int fails = 0;

    logic [7:0] mm [512];
    bit         kn [512];
    bit         pr [4];
    bit         bk;
    logic [7:0] ma;

    always #10 clk = ~clk;

    i2c_banked_eeprom #(.WC_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(STRAP), .hv_i(hv_i),
        .start_i(start_i), .stop_i(stop_i), .rx_valid_i(rx_valid_i),
        .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i), .ack_valid_o(ack_valid_o),
        .ack_o(ack_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [7:0] prot_cmd(input logic [1:0] b);
        return {4'b0110, 1'b0, b, 1'b0};
    endfunction

    function automatic bit exp_data_ack(input logic [7:0] a);
        return !pr[{bk, a[7]}];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, output bit a);
        @(negedge clk) begin rx_valid_i = 1'b1; rx_byte_i = b; end
        @(negedge clk) rx_valid_i = 1'b0;
        a = ack_valid_o && ack_o;
    endtask

    task automatic get(output logic [7:0] v);
        @(negedge clk) tx_req_i = 1'b1;
        @(negedge clk) tx_req_i = 1'b0;
        v = rd_valid_o ? rd_data_o : 8'hxx;
    endtask

    task automatic wait_ready();
        bit a;
        int n = 0;
        do begin
            bus_start(); put(CTL_W, a); bus_stop(); n++;
        end while (!a && n < 100);
        chk(a, "R5 write cycle ends", a, 1);
    endtask

    task automatic mem_write(input logic [7:0] a0, input int n, input bit rnd);
        bit a;
        logic [7:0] pd [16];
        bit pv [16];
        logic [7:0] base;
        bit any = 0;
        for (int i = 0; i < 16; i++) pv[i] = 0;
        bus_start();
        put(CTL_W, a); chk(a == 1, "R2 write control ack", a, 1);
        put(a0, a);    chk(a == 1, "R4 address ack", a, 1);
        ma = a0;
        base = a0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v = rnd ? 8'($urandom) : 8'(a0 + i * 7);
            bit e = exp_data_ack(ma);
            put(v, a);
            chk(a == e, e ? "R4 data ack" : "R6 protected data nack", a, e);
            if (e) begin
                pd[ma[3:0]] = v; pv[ma[3:0]] = 1; any = 1;
                ma = {ma[7:4], 4'(ma[3:0] + 1)};
            end
        end
        bus_stop();
        if (any) begin
            for (int i = 0; i < 16; i++)
                if (pv[i]) begin
                    mm[{bk, base[7:4], 4'(i)}] = pd[i];
                    kn[{bk, base[7:4], 4'(i)}] = 1;
                end
            wait_ready();
        end else begin
            bus_start(); put(CTL_W, a); bus_stop();
            chk(a == 1, "R6 no write cycle after refused data", a, 1);
        end
    endtask

    task automatic mem_read(input logic [7:0] a0, input int n, input string tag);
        bit a;
        logic [7:0] v;
        bus_start();
        put(CTL_W, a); put(a0, a);
        bus_start();
        put(CTL_R, a); chk(a == 1, "R2 read control ack", a, 1);
        ma = a0;
        for (int i = 0; i < n; i++) begin
            get(v);
            if (kn[{bk, ma}]) chk(v === mm[{bk, ma}], tag, v, mm[{bk, ma}]);
            ma = ma + 1;
        end
        bus_stop();
    endtask

    task automatic set_prot(input logic [1:0] b, input bit hv);
        bit a;
        hv_i = hv;
        bus_start(); put(prot_cmd(b), a); bus_stop();
        hv_i = 1'b0;
        chk(a == hv, "R7 protect set ack", a, hv);
        if (hv) pr[b] = 1;
    endtask

    task automatic clr_prot(input bit hv);
        bit a;
        hv_i = hv;
        bus_start(); put(PCLR, a); bus_stop();
        hv_i = 1'b0;
        chk(a == hv, "R7 protect clear ack", a, hv);
        if (hv) for (int i = 0; i < 4; i++) pr[i] = 0;
    endtask

    task automatic sel_bank(input bit b);
        bit a;
        bus_start(); put(b ? BSEL1 : BSEL0, a); bus_stop();
        chk(a == 1, "R8 bank select ack", a, 1);
        bk = b;
        bus_start(); put(BREAD, a); bus_stop();
        chk(a == !bk, "R8 bank status", a, !bk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] v;
        void'($urandom(32'd2024));
        for (int i = 0; i < 512; i++) kn[i] = 0;
        for (int i = 0; i < 4; i++) pr[i] = 0;
        bk = 0; ma = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ack_valid_o && !rd_valid_o, "R1 reset outputs", {ack_valid_o, rd_valid_o}, 0);
        bus_start(); put(BREAD, a); bus_stop();
        chk(a == 1, "R1 bank 0 after reset", a, 1);

        // R2 strap mismatch
        bus_start(); put({4'b1010, ~STRAP, 1'b0}, a); bus_stop();
        chk(a == 0, "R2 strap mismatch nack", a, 0);

        // R4 full page then read back, then over-long page with wrap
        mem_write(8'h10, 16, 0);
        mem_read(8'h10, 16, "R10 page readback");
        mem_write(8'h3E, 18, 1);
        mem_read(8'h30, 16, "R4 page wrap content");

        // R5 busy timing
        mem_write(8'h50, 0, 0);
        bus_start(); put(CTL_W, a); put(8'h50, a); put(8'h77, a); bus_stop();
        bus_start(); put(CTL_W, a); bus_stop();
        chk(a == 0, "R5 nack right after stop", a, 0);
        repeat (WC - 24) @(negedge clk);
        bus_start(); put(CTL_W, a); bus_stop();
        chk(a == 0, "R5 nack late in write cycle", a, 0);
        repeat (20) @(negedge clk);
        bus_start(); put(CTL_W, a); bus_stop();
        chk(a == 1, "R5 ack after write cycle", a, 1);
        mm[{1'b0, 8'h50}] = 8'h77; kn[{1'b0, 8'h50}] = 1;

        // R3 sequential wrap inside bank
        mem_write(8'hFE, 2, 0);
        mem_write(8'h00, 2, 0);
        mem_read(8'hFE, 4, "R3 sequential wrap");

        // R7 without qualifier, then R6 with protection
        set_prot(2'd1, 0);
        mem_write(8'h80, 2, 0);
        set_prot(2'd1, 1);
        mem_write(8'h80, 3, 0);
        mem_read(8'h80, 2, "R6 protected bytes unchanged");
        clr_prot(0);
        mem_write(8'h81, 1, 0);
        clr_prot(1);
        mem_write(8'h80, 2, 1);
        mem_read(8'h80, 2, "R7 write after clear");

        // R8 bank selection ignores straps, R10 bank isolation
        sel_bank(1);
        mem_write(8'h10, 4, 1);
        mem_read(8'h10, 4, "R10 bank 1 readback");
        set_prot(2'd3, 1);
        mem_write(8'hC0, 1, 0);
        sel_bank(0);
        mem_write(8'hC0, 1, 0);
        mem_read(8'h10, 4, "R10 bank 0 untouched");
        clr_prot(1);

        // R9 repeated start drops buffered data
        mem_write(8'h20, 16, 0);
        bus_start(); put(CTL_W, a); put(8'h20, a); put(8'hA5, a);
        bus_start(); put(CTL_W, a); put(8'h20, a);
        bus_start(); put(CTL_R, a); get(v); bus_stop();
        chk(v === mm[{1'b0, 8'h20}], "R9 discarded data", v, mm[{1'b0, 8'h20}]);
        bus_start(); put(CTL_W, a); bus_stop();
        chk(a == 1, "R9 no write cycle started", a, 1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int unsigned r = $urandom % 6;
            case (r)
                0, 1: mem_write(8'($urandom), 1 + ($urandom % 18), 1);
                2, 3: mem_read(8'($urandom), 1 + ($urandom % 8), "R10 random read");
                4: if ($urandom % 3 == 0) clr_prot(1);
                   else set_prot(2'($urandom), 1'($urandom));
                default: sel_bank(1'($urandom));
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule